// File: doc/BRIEF.md
# Flags Register Pop Merger

This block decides what the processor status-flags register becomes when a value taken off the stack is loaded into it. Each request carries the popped word, the operating mode, the current privilege level, the enable for the virtual-8086 extensions and the operand size. The block builds a per-bit write mask from these inputs. Bits inside the mask take the popped value. Bits outside it keep their current value. A small set of bits is always forced to fixed values. The flags register itself lives inside the block and is visible on `flags_o`.

Every accepted request produces one result beat. The beat carries the stack-pointer increment and a general-protection fault flag. Requests arrive on a valid/ready channel. A request is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`, so a result that has not been consumed blocks the next request. The result stays on the output, unchanged, until `out_ready` is seen high. Stack memory is handled elsewhere: the popped word arrives already fetched.

Encodings: `in_mode` is 0 for real, 1 for protected, 2 for virtual-8086 and 3 for 64-bit. `in_osize` is 0 for 16 bits, 1 for 32 bits and 2 for 64 bits; 3 is reserved. The flag positions are IF at bit 9, the I/O privilege field (IOPL) at bits 13:12, VM at bit 17, VIF at bit 19 and VIP at bit 20.

Top module: `flags_pop_unit`

## Requirements
- R1: After reset `flags_o` is 0x2, `out_valid` is low and `in_ready` is high.
- R2: The result beat reports an increment of 2, 4 or 8 for operand size 0, 1 or 2. On a faulted request it reports 0.
- R3: The writable flags are bits 0, 2, 4, 6, 7, 8, 10, 11, 14, 16, 18 and 21, plus IF and IOPL when R4 and R5 allow. These bits take the popped value. VM (17), VIF (19) and VIP (20) always keep their current value.
- R4: The IOPL field (13:12) is written only when the effective privilege is 0. Real mode counts as privilege 0, virtual-8086 mode as privilege 3, and the other modes use `in_cpl`.
- R5: IF (bit 9) is written only when the effective privilege is less than or equal to the current IOPL. Otherwise it keeps its value.
- R6: A request faults in virtual-8086 mode when the current IOPL is below 3 and either `in_vme` is low or the operand size is not 16 bits.
- R7: A request faults when the operand size is 3, when it is 32 bits in 64-bit mode, or when it is 64 bits in any other mode.
- R8: Bit 1 of `flags_o` is always 1. Bits 3, 5, 15 and everything from bit 22 upward are always 0, whatever value was popped.
- R9: A 16-bit pop affects only bits 15:0. Bits above 15 keep their current value.
- R10: A faulted request raises `out_fault` in its result beat and leaves `flags_o` unchanged.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low, no request is taken, and the result beat and `flags_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_pop | input | FLAGS_W | Word popped from the stack |
| in_mode | input | 2 | Operating mode (0 real, 1 protected, 2 virtual-8086, 3 64-bit) |
| in_cpl | input | 2 | Current privilege level |
| in_vme | input | 1 | Virtual-8086 extensions enabled |
| in_osize | input | 2 | Operand size (0 16-bit, 1 32-bit, 2 64-bit, 3 reserved) |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_sp_delta | output | 4 | Stack-pointer increment in bytes |
| out_fault | output | 1 | General-protection fault for this request |
| flags_o | output | FLAGS_W | Current flags register |

## Verification
The privilege rule for IF and the rule for the IOPL field are both applied to the same pop. Both read the current IOPL while the same popped word may be rewriting that field. The bench provokes this with pops that set IOPL to 3 from privilege 0, and with pops at privilege 1 to 3 whose words try to clear IF and IOPL. It then judges each bit of `flags_o` separately against values worked out by hand. A second overlap comes from back-pressure: a new request waits on `in_valid` while the previous result is stalled. The bench checks that the waiting request changes nothing until `out_ready` rises, and that it then takes effect in the same edge that retires the old beat.

// File: rtl/flags_pop_pkg.sv
package flags_pop_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;

  typedef enum logic [1:0] {
    OSZ_16  = 2'd0,
    OSZ_32  = 2'd1,
    OSZ_64  = 2'd2,
    OSZ_BAD = 2'd3
  } op_size_e;

  // flag positions the merge rules depend on
  localparam int IF_POS     = 9;
  localparam int IOPL_LO    = 12;
  localparam int IOPL_HI    = 13;
  localparam int VM_POS     = 17;
  localparam int VIF_POS    = 19;
  localparam int VIP_POS    = 20;
  localparam int TOP_DEFINED = 21;

  // bits a pop may always write (IF and IOPL are added per privilege)
  localparam logic [63:0] FREE_WMASK = 64'h0000_0000_0025_4DD5;
  localparam logic [63:0] FLAGS_RST  = 64'h0000_0000_0000_0002;

endpackage

// File: rtl/flags_pop_gate.sv
module flags_pop_gate
  import flags_pop_pkg::*;
#(
  parameter int FW = 64
) (
  input  cpu_mode_e       mode,
  input  logic [1:0]      cpl,
  input  logic            vme,
  input  op_size_e        osize,
  input  logic [FW-1:0]   cur_flags,
  output logic [FW-1:0]   wmask,
  output logic            fault
);

  localparam logic [FW-1:0] LOW16 = FW'(64'h0000_0000_0000_FFFF);
  localparam logic [FW-1:0] LOW32 = FW'(64'h0000_0000_FFFF_FFFF);

  logic [1:0] priv_eff;
  logic [1:0] cur_iopl;
  logic       if_ok;
  logic       iopl_ok;
  logic       size_bad;
  logic       v86_bad;

  assign cur_iopl = cur_flags[IOPL_HI:IOPL_LO];

  // real mode acts as most privileged, virtual-8086 as least
  always_comb begin
    unique case (mode)
      MODE_REAL: priv_eff = 2'd0;
      MODE_V86:  priv_eff = 2'd3;
      default:   priv_eff = cpl;
    endcase
  end

  assign if_ok   = (priv_eff <= cur_iopl);
  assign iopl_ok = (priv_eff == 2'd0);

  always_comb begin
    size_bad = 1'b0;
    if (osize == OSZ_BAD)                          size_bad = 1'b1;
    if ((mode == MODE_LONG) && (osize == OSZ_32))  size_bad = 1'b1;
    if ((mode != MODE_LONG) && (osize == OSZ_64))  size_bad = 1'b1;
  end

  assign v86_bad = (mode == MODE_V86) && (cur_iopl != 2'd3) &&
                   (!vme || (osize != OSZ_16));
  assign fault   = size_bad || v86_bad;

  always_comb begin
    wmask = FREE_WMASK[FW-1:0];
    if (if_ok)   wmask[IF_POS] = 1'b1;
    if (iopl_ok) wmask[IOPL_HI:IOPL_LO] = 2'b11;
    unique case (osize)
      OSZ_16:  wmask = wmask & LOW16;
      OSZ_32:  wmask = wmask & LOW32;
      default: wmask = wmask;
    endcase
  end

endmodule

// File: rtl/flags_pop_merge.sv
module flags_pop_merge
  import flags_pop_pkg::*;
#(
  parameter int FW = 64
) (
  input  logic [FW-1:0] cur_flags,
  input  logic [FW-1:0] popped,
  input  logic [FW-1:0] wmask,
  output logic [FW-1:0] nxt_flags
);

  logic [FW-1:0] blended;

  assign blended = (cur_flags & ~wmask) | (popped & wmask);

  // fixed bits: 1 is set, 3/5/15 and undefined high bits are clear
  for (genvar b = 0; b < FW; b++) begin : g_fix
    if (b == 1) begin : g_one
      assign nxt_flags[b] = 1'b1;
    end else if ((b == 3) || (b == 5) || (b == 15) || (b > TOP_DEFINED)) begin : g_zero
      assign nxt_flags[b] = 1'b0;
    end else begin : g_pass
      assign nxt_flags[b] = blended[b];
    end
  end

endmodule

// File: rtl/flags_pop_step.sv
module flags_pop_step
  import flags_pop_pkg::*;
#(
  parameter int DW = 4
) (
  input  op_size_e      osize,
  output logic [DW-1:0] delta
);

  always_comb begin
    unique case (osize)
      OSZ_16:  delta = DW'(2);
      OSZ_32:  delta = DW'(4);
      OSZ_64:  delta = DW'(8);
      default: delta = '0;
    endcase
  end

endmodule

// File: rtl/flags_pop_unit.sv
module flags_pop_unit
  import flags_pop_pkg::*;
#(
  parameter int FLAGS_W = 64,
  localparam int DELTA_W = $clog2(FLAGS_W / 8) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FLAGS_W-1:0] in_pop,
  input  logic [1:0]         in_mode,
  input  logic [1:0]         in_cpl,
  input  logic               in_vme,
  input  logic [1:0]         in_osize,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DELTA_W-1:0] out_sp_delta,
  output logic               out_fault,
  output logic [FLAGS_W-1:0] flags_o
);

  cpu_mode_e          mode_c;
  op_size_e           osz_c;
  logic [FLAGS_W-1:0] wmask_c;
  logic [FLAGS_W-1:0] nxt_c;
  logic               fault_c;
  logic [DELTA_W-1:0] step_c;
  logic               take;

  assign mode_c   = cpu_mode_e'(in_mode);
  assign osz_c    = op_size_e'(in_osize);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  flags_pop_gate #(.FW(FLAGS_W)) u_gate (
    .mode      (mode_c),
    .cpl       (in_cpl),
    .vme       (in_vme),
    .osize     (osz_c),
    .cur_flags (flags_o),
    .wmask     (wmask_c),
    .fault     (fault_c)
  );

  flags_pop_merge #(.FW(FLAGS_W)) u_merge (
    .cur_flags (flags_o),
    .popped    (in_pop),
    .wmask     (wmask_c),
    .nxt_flags (nxt_c)
  );

  flags_pop_step #(.DW(DELTA_W)) u_step (
    .osize (osz_c),
    .delta (step_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_o      <= FLAGS_RST[FLAGS_W-1:0];
      out_valid    <= 1'b0;
      out_sp_delta <= '0;
      out_fault    <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_fault    <= fault_c;
      out_sp_delta <= fault_c ? '0 : step_c;
      if (!fault_c) flags_o <= nxt_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_fixed_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[1] && !flags_o[3] && !flags_o[5] && !flags_o[15]);

  assert_virt_bits_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (flags_o[VM_POS] == $past(flags_o[VM_POS])) &&
             (flags_o[VIF_POS] == $past(flags_o[VIF_POS])) &&
             (flags_o[VIP_POS] == $past(flags_o[VIP_POS])));

  assert_fault_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fault_c) |=> (flags_o == $past(flags_o)) && out_fault);

  assert_hold_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_sp_delta) &&
                                  $stable(out_fault) && $stable(flags_o));

  assert_delta_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fault ? (out_sp_delta == '0) : ($countones(out_sp_delta) == 1)));

  assert_iopl_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (mode_c == MODE_PROT) && (in_cpl != 2'd0)) |=>
      (flags_o[IOPL_HI:IOPL_LO] == $past(flags_o[IOPL_HI:IOPL_LO])));

  assert_if_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (mode_c == MODE_PROT) && (in_cpl > flags_o[IOPL_HI:IOPL_LO])) |=>
      (flags_o[IF_POS] == $past(flags_o[IF_POS])));

endmodule

// File: tb/flags_pop_unit_test.sv
module flags_pop_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 64;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  cpl;
    logic        vme;
    logic [1:0]  osz;
    logic [63:0] pop;
    logic [63:0] exp_flags;
    logic [3:0]  exp_delta;
    logic        exp_fault;
  } vec_t;

  localparam int NV = 17;
  // rows are applied in order; each expectation follows from the row before
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b0, 2'd1, 64'hFFFF_FFFF, 64'h257FD7, 4'd4, 1'b0}, // R3 R8 real, all writable
    '{2'd1, 2'd3, 1'b0, 2'd1, 64'h0,         64'h3002,   4'd4, 1'b0}, // R4 IOPL kept at cpl3
    '{2'd1, 2'd3, 1'b0, 2'd0, 64'hFFFF,      64'h7FD7,   4'd2, 1'b0}, // R9 R5 16-bit
    '{2'd1, 2'd0, 1'b0, 2'd1, 64'h200,       64'h202,    4'd4, 1'b0}, // R4 cpl0 writes IOPL
    '{2'd1, 2'd2, 1'b0, 2'd1, 64'hFFFF_FFFF, 64'h254FD7, 4'd4, 1'b0}, // R5 IF blocked
    '{2'd1, 2'd2, 1'b0, 2'd1, 64'h0,         64'h202,    4'd4, 1'b0}, // R5 IF cannot clear
    '{2'd2, 2'd0, 1'b0, 2'd0, 64'hFFFF,      64'h202,    4'd0, 1'b1}, // R6 no extensions
    '{2'd2, 2'd0, 1'b1, 2'd1, 64'hFFFF,      64'h202,    4'd0, 1'b1}, // R6 32-bit in v86
    '{2'd2, 2'd0, 1'b1, 2'd0, 64'hFFFF,      64'h4FD7,   4'd2, 1'b0}, // R6 allowed path
    '{2'd3, 2'd0, 1'b0, 2'd1, 64'hFFFF,      64'h4FD7,   4'd0, 1'b1}, // R7 32-bit in 64-bit mode
    '{2'd3, 2'd0, 1'b0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h257FD7, 4'd8, 1'b0}, // R2 R8 R3
    '{2'd3, 2'd0, 1'b0, 2'd0, 64'h0,         64'h250002, 4'd2, 1'b0}, // R9 upper kept
    '{2'd0, 2'd0, 1'b0, 2'd2, 64'h0,         64'h250002, 4'd0, 1'b1}, // R7 64-bit outside
    '{2'd1, 2'd0, 1'b0, 2'd3, 64'h0,         64'h250002, 4'd0, 1'b1}, // R7 reserved size
    '{2'd0, 2'd0, 1'b0, 2'd1, 64'h3000,      64'h3002,   4'd4, 1'b0}, // R4 real writes IOPL
    '{2'd2, 2'd0, 1'b0, 2'd1, 64'hFFFF_FFFF, 64'h257FD7, 4'd4, 1'b0}, // R6 IOPL3 no fault
    '{2'd0, 2'd0, 1'b0, 2'd0, 64'h0,         64'h250002, 4'd2, 1'b0}  // R9 real 16-bit
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [FW-1:0] in_pop = '0;
  logic [1:0]    in_mode = '0;
  logic [1:0]    in_cpl = '0;
  logic          in_vme = 1'b0;
  logic [1:0]    in_osize = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [3:0]    out_sp_delta;
  logic          out_fault;
  logic [FW-1:0] flags_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flags_pop_unit #(.FLAGS_W(FW)) uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_pop, .in_mode, .in_cpl,
    .in_vme, .in_osize, .out_valid, .out_ready, .out_sp_delta,
    .out_fault, .flags_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_mode  = v.mode;
    in_cpl   = v.cpl;
    in_vme   = v.vme;
    in_osize = v.osz;
    in_pop   = v.pop;
    in_valid = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 flags after reset", flags_o, 64'h2);
    chk("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R1 in_ready after reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      $display("row %0d", i);
      chk("R3 R4 R5 R6 R7 R8 R9 R10 flags", flags_o, VECS[i].exp_flags);
      chk("R2 sp delta", {60'd0, out_sp_delta}, {60'd0, VECS[i].exp_delta});
      chk("R6 R7 R10 fault", {63'd0, out_fault}, {63'd0, VECS[i].exp_fault});
    end

    // back-pressure: stalled result blocks a waiting request (R11)
    @(negedge clk);
    out_ready = 1'b0;
    drive('{2'd0, 2'd0, 1'b0, 2'd1, 64'h0, 64'h2, 4'd4, 1'b0});
    @(posedge clk);
    @(negedge clk);
    chk("R11 first beat flags", flags_o, 64'h2);
    chk("R11 ready low while stalled", {63'd0, in_ready}, 64'd0);
    drive('{2'd0, 2'd0, 1'b0, 2'd0, 64'h200, 64'h202, 4'd2, 1'b0});
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11 waiting request not applied", flags_o, 64'h2);
    chk("R11 beat held valid", {63'd0, out_valid}, 64'd1);
    chk("R11 beat delta held", {60'd0, out_sp_delta}, 64'd4);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 R9 waiting request applied", flags_o, 64'h202);
    chk("R11 R2 new delta", {60'd0, out_sp_delta}, 64'd2);
    @(posedge clk);
    @(negedge clk);
    chk("R11 beat retired", {63'd0, out_valid}, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule